// File: doc/BRIEF.md
# Dual-Line Fast Read Serializer

This block runs the data side of the two fast-read variants of a serial flash slave that move data on two lines. A command front-end decodes the opcode. It pulses `start` and selects the variant on `dual_io`. From then on the block owns the transaction. It collects the 24-bit byte address, waits out the dummy clocks and fetches bytes from a synchronous read port. It sends every byte two bits per serial clock on the data-output line and on the data-input line. The input line is turned around to drive only once the dummy clocks are over.

The block is clocked by the serial clock. Host bits are sampled on rising edges, and new output bits are launched on falling edges. Bytes are read one at a time from the array port. The next byte is fetched while the current one is still being shifted, so the host sees a continuous stream. The address advances after each byte and wraps at the top of the array. The stream runs until chip-select goes high, and that may happen in the middle of a byte.

Top module: `dual_read_ser`

## Requirements
- R1: While `rst` is high and after it is released, `di_oe`, `do_oe` and `rd_req` are low and the block waits for `start`.
- R2: With `dual_io`=0, the 24 address bits arrive one per rising edge on `di_in`, most significant bit first. Eight dummy clocks follow.
- R3: With `dual_io`=1, the address arrives in 12 rising edges, two bits each. `do_in` carries the odd bits (A23, A21 … A1) and `di_in` carries the even bits (A22, A20 … A0). Four dummy clocks follow.
- R4: In the data phase each byte takes four clocks. On successive clocks `do_out` carries D7, D5, D3, D1 and `di_out` carries D6, D4, D2, D0, so the host samples the pair (D7,D6) first.
- R5: `di_oe` and `do_oe` rise at the falling edge right after the last dummy clock. They fall in the same instant that `cs_n` goes high, with no clock edge needed.
- R6: The first byte is read at the low `AW` bits of the received address, and each later byte at the previous address plus one, modulo 2^AW. The address bits above `AW` are ignored.
- R7: Bytes follow one another with no idle clock, for any number of bytes.
- R8: A high `cs_n` at a rising edge ends the transaction in any phase. `start` is only accepted when the block is idle and `cs_n` is low. A transaction cut off early has no effect on the next one.
- R9: `rd_req` is a single-cycle pulse. `rd_data` is taken as valid one clock after the edge that sampled the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select, active low |
| start | input | 1 | Opcode decoded; the next rising edge carries the first address bit |
| dual_io | input | 1 | 0: single-line address, 1: two-line address |
| di_in | input | 1 | Value on the data-input line |
| do_in | input | 1 | Value on the data-output line (address bits when dual_io=1) |
| di_out | output | 1 | Even data bit driven onto the data-input line |
| di_oe | output | 1 | Drive enable of the data-input line |
| do_out | output | 1 | Odd data bit driven onto the data-output line |
| do_oe | output | 1 | Drive enable of the data-output line |
| rd_req | output | 1 | Read request to the array port |
| rd_addr | output | AW | Read address |
| rd_data | input | 8 | Read data, valid one clock after the request |

## Verification
A wrong address counter shows up at the ports one byte at a time. The first two-bit pair of the affected byte, four clocks after the previous byte's first pair, carries the wrong data, so the stream is checked pair by pair against a function of the address. A wrong phase length or a wrong bit split between the lines shifts every pair from the first data clock on. It is caught on that clock, and the enables are checked on every address and dummy clock so that early driving is seen there. Abort handling is tested by cutting transactions at random pairs and in the address phase, then checking that the next transaction is clean from its first clock.

// File: rtl/dual_read_pkg.sv
package dual_read_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_DUMMY = 2'd2,
    ST_DATA  = 2'd3
  } rd_state_t;
endpackage

// File: rtl/dual_addr_shift.sv
module dual_addr_shift #(
  parameter int HOST_AW = 24
) (
  input  logic               clk,
  input  logic               clear,
  input  logic               shift_en,
  input  logic               two_line,
  input  logic               odd_bit,
  input  logic               even_bit,
  output logic [HOST_AW-1:0] addr_next
);
  logic [HOST_AW-1:0] addr_q;

  always_comb begin
    if (two_line) addr_next = {addr_q[HOST_AW-3:0], odd_bit, even_bit};
    else          addr_next = {addr_q[HOST_AW-2:0], even_bit};
  end

  always_ff @(posedge clk) begin
    if (clear)         addr_q <= '0;
    else if (shift_en) addr_q <= addr_next;
  end
endmodule

// File: rtl/dual_byte_fetch.sv
module dual_byte_fetch #(
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          abort,
  input  logic          first_req,
  input  logic [AW-1:0] first_addr,
  input  logic          load,
  input  logic [7:0]    rd_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic [7:0]    cur
);
  logic       pend_q;
  logic [7:0] nxt_q;

  always_ff @(posedge clk) begin
    if (abort) begin
      rd_req  <= 1'b0;
      pend_q  <= 1'b0;
      rd_addr <= '0;
    end else begin
      pend_q <= rd_req;
      if (first_req) begin
        rd_req  <= 1'b1;
        rd_addr <= first_addr;
      end else if (load) begin
        rd_req  <= 1'b1;
        rd_addr <= rd_addr + 1'b1;
      end else begin
        rd_req  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (abort) begin
      nxt_q <= '0;
      cur   <= '0;
    end else begin
      if (pend_q) nxt_q <= rd_data;
      if (load)   cur   <= nxt_q;
    end
  end
endmodule

// File: rtl/dual_pin_driver.sv
module dual_pin_driver (
  input  logic       clk,
  input  logic       rst,
  input  logic       active,
  input  logic [7:0] cur,
  input  logic [1:0] pair_idx,
  output logic       odd_q,
  output logic       even_q,
  output logic       oe_q
);
  logic [7:0] aligned;

  always_comb aligned = cur << {pair_idx, 1'b0};

  always_ff @(negedge clk) begin
    if (rst) begin
      oe_q   <= 1'b0;
      odd_q  <= 1'b0;
      even_q <= 1'b0;
    end else begin
      oe_q   <= active;
      odd_q  <= aligned[7];
      even_q <= aligned[6];
    end
  end
endmodule

// File: rtl/dual_read_ser.sv
module dual_read_ser
  import dual_read_pkg::*;
#(
  parameter int AW           = 18,
  parameter int HOST_AW      = 24,
  parameter int DUMMY_SINGLE = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          start,
  input  logic          dual_io,
  input  logic          di_in,
  input  logic          do_in,
  output logic          di_out,
  output logic          di_oe,
  output logic          do_out,
  output logic          do_oe,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data
);
  localparam int CW          = $clog2(HOST_AW + 1);
  localparam int ADDR_LAST_1 = HOST_AW - 1;
  localparam int ADDR_LAST_2 = HOST_AW / 2 - 1;
  localparam int DUM_LAST_1  = DUMMY_SINGLE - 1;
  localparam int DUM_LAST_2  = DUMMY_SINGLE / 2 - 1;

  rd_state_t         state;
  logic [CW-1:0]     cnt;
  logic              mode_q;
  logic              abort;
  logic              addr_done;
  logic              dummy_done;
  logic              byte_load;
  logic [HOST_AW-1:0] addr_full;
  logic [7:0]        cur_byte;
  logic              odd_q, even_q, oe_q;

  assign abort      = rst | cs_n;
  assign addr_done  = (state == ST_ADDR) &&
                      (cnt == CW'(mode_q ? ADDR_LAST_2 : ADDR_LAST_1));
  assign dummy_done = (state == ST_DUMMY) &&
                      (cnt == CW'(mode_q ? DUM_LAST_2 : DUM_LAST_1));
  assign byte_load  = dummy_done || ((state == ST_DATA) && (cnt[1:0] == 2'd3));

  always_ff @(posedge clk) begin
    if (abort) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      mode_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start) begin
            state  <= ST_ADDR;
            mode_q <= dual_io;
          end
        end
        ST_ADDR: begin
          if (addr_done) begin
            state <= ST_DUMMY;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DUMMY: begin
          if (dummy_done) begin
            state <= ST_DATA;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: cnt <= cnt + 1'b1;
      endcase
    end
  end

  dual_addr_shift #(.HOST_AW(HOST_AW)) u_addr (
    .clk      (clk),
    .clear    (abort || state == ST_IDLE),
    .shift_en (state == ST_ADDR),
    .two_line (mode_q),
    .odd_bit  (do_in),
    .even_bit (di_in),
    .addr_next(addr_full)
  );

  dual_byte_fetch #(.AW(AW)) u_fetch (
    .clk       (clk),
    .abort     (abort),
    .first_req (addr_done),
    .first_addr(addr_full[AW-1:0]),
    .load      (byte_load),
    .rd_data   (rd_data),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .cur       (cur_byte)
  );

  dual_pin_driver u_pins (
    .clk     (clk),
    .rst     (rst),
    .active  (state == ST_DATA),
    .cur     (cur_byte),
    .pair_idx(cnt[1:0]),
    .odd_q   (odd_q),
    .even_q  (even_q),
    .oe_q    (oe_q)
  );

  assign do_out = odd_q;
  assign di_out = even_q;
  assign do_oe  = oe_q & ~cs_n;
  assign di_oe  = oe_q & ~cs_n;
endmodule

// File: rtl/dual_read_ser_chk.sv
module dual_read_ser_chk
  import dual_read_pkg::*;
#(
  parameter int AW      = 18,
  parameter int CW      = 5,
  parameter int HOST_AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  rd_state_t     state,
  input  logic [CW-1:0] cnt,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  input  logic          oe_q
);
  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (state == ST_IDLE));

  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_req && state == ST_DATA && $past(state) == ST_DATA) |->
      (rd_addr == AW'($past(rd_addr) + 1'b1)));

  assert_drive_in_data_R5: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> (state == ST_DATA));

  assert_addr_len_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR) |-> (cnt < CW'(HOST_AW)));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !rd_req);
endmodule

bind dual_read_ser dual_read_ser_chk #(.AW(AW), .CW(CW), .HOST_AW(HOST_AW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .cs_n   (cs_n),
  .state  (state),
  .cnt    (cnt),
  .rd_req (rd_req),
  .rd_addr(rd_addr),
  .oe_q   (oe_q)
);

// File: tb/dual_read_ser_tb.sv
`timescale 1ns/1ps
module dual_read_ser_tb;
  localparam int BAW = 10;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cs_n = 1'b1;
  logic           start = 1'b0;
  logic           dual_io = 1'b0;
  logic           di_in = 1'b0;
  logic           do_in = 1'b0;
  logic           di_out, di_oe, do_out, do_oe, rd_req;
  logic [BAW-1:0] rd_addr;
  logic [7:0]     rd_data = 8'h00;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  dual_read_ser #(.AW(BAW)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .start(start), .dual_io(dual_io),
    .di_in(di_in), .do_in(do_in), .di_out(di_out), .di_oe(di_oe),
    .do_out(do_out), .do_oe(do_oe), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  function automatic logic [7:0] fbyte(input int unsigned ad);
    int unsigned t;
    t = (ad * 37 + 91) ^ (ad >> 3);
    return t[7:0];
  endfunction

  always @(posedge clk) if (rd_req) rd_data <= fbyte(32'(rd_addr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_txn(input bit dual, input logic [23:0] a, input int npairs);
    int nclk;
    int nd;
    nclk = dual ? 12 : 24;
    nd   = dual ? 4 : 8;
    @(negedge clk); #2;
    cs_n = 1'b0; start = 1'b1; dual_io = dual;
    for (int i = 0; i < nclk; i++) begin
      @(negedge clk); #2;
      start = 1'b0;
      if (dual) begin
        do_in = a[23-2*i];
        di_in = a[22-2*i];
      end else begin
        di_in = a[23-i];
        do_in = $urandom % 2;
      end
      chk(!di_oe && !do_oe, dual ? "R3 no drive in addr" : "R2 no drive in addr",
          {di_oe, do_oe}, 0);
    end
    for (int i = 0; i < nd; i++) begin
      @(negedge clk); #2;
      di_in = 1'b0; do_in = 1'b0;
      chk(!di_oe && !do_oe, "R5 no drive in dummy", {di_oe, do_oe}, 0);
    end
    for (int j = 0; j < npairs; j++) begin
      logic [7:0] e;
      int p;
      @(negedge clk); #2;
      p = j % 4;
      e = fbyte((32'(a) + 32'(j / 4)) % (1 << BAW));
      chk(di_oe && do_oe, "R5 drive in data", {di_oe, do_oe}, 3);
      chk({do_out, di_out} == {e[7-2*p], e[6-2*p]},
          (j >= 4) ? "R7 R6 pair" : "R4 pair", {do_out, di_out},
          {e[7-2*p], e[6-2*p]});
    end
    @(negedge clk); #2;
    cs_n = 1'b1;
    #1;
    chk(!di_oe && !do_oe, "R5 release on cs", {di_oe, do_oe}, 0);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7021));
    repeat (3) @(negedge clk);
    #2;
    chk(!di_oe && !do_oe && !rd_req, "R1 reset quiet", {di_oe, do_oe, rd_req}, 0);
    rst = 1'b0;
    @(negedge clk); #2;
    chk(!di_oe && !do_oe && !rd_req, "R1 after reset", {di_oe, do_oe, rd_req}, 0);

    run_txn(1'b0, 24'h000123, 16);
    run_txn(1'b1, 24'h0002A5, 16);
    run_txn(1'b1, 24'hABC3FE, 16);
    run_txn(1'b0, 24'h5553FF, 9);
    run_txn(1'b1, 24'h000040, 1);

    @(negedge clk); #2;
    cs_n = 1'b0; start = 1'b1; dual_io = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #2;
      start = 1'b0; do_in = 1'b1; di_in = 1'b1;
    end
    cs_n = 1'b1;
    @(negedge clk);
    run_txn(1'b0, 24'h000077, 8);

    @(negedge clk); #2;
    cs_n = 1'b1; start = 1'b1; dual_io = 1'b0;
    @(negedge clk); #2;
    start = 1'b0; cs_n = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #2;
      di_in = $urandom % 2;
      chk(!di_oe && !do_oe && !rd_req, "R8 start ignored while deselected",
          {di_oe, do_oe, rd_req}, 0);
    end
    cs_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 14; k++) begin
      logic [23:0] ra;
      ra = 24'($urandom);
      run_txn(1'($urandom % 2), ra, 1 + int'($urandom % 24));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule